// File: doc/BRIEF.md
# Polled UART with Register-Bus Handshake

This block is a small serial port that software drives through three 32-bit registers on a simple register bus. Sending and receiving both work by polling status bits in the data word: a write with the "launch" bit set places one byte into a transmit holding stage, and the transmitter pulls it into its shift register as soon as the line is free and flow control allows. A received byte waits in a single receive holding stage until software acknowledges it by writing a 1 to the "byte waiting" bit.

The serial line carries 8N1 frames: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The bit rate comes from an external generator as a single-cycle tick at sixteen times the bit rate. The transmitter counts sixteen ticks per bit. The receiver finds the middle of each bit from the falling edge of the start bit. The clock register holds a 12-bit scale and a 16-bit step for that external generator and drives them out on a port. The interface-mode and ready-override fields are stored and read back. The transmit-ready override also decides whether the clear-to-send input gates the start of a frame.

Top module: `uart_mmio_core`

## Requirements
- R1: After reset, offset 0x0 reads 0x0000_0200, offsets 0x4 and 0x8 read 0, and the unmapped offset 0xC always reads 0.
- R2: Data register (offset 0x0): bits 7:0 hold the byte and bit 9 reads 1 while the transmit holding stage is empty. A write with bit 9 set loads bits 7:0, and bit 9 reads 0 until the transmitter takes the byte. A write with bit 9 clear sends nothing.
- R3: The txd output idles high. Each frame is a 0 start bit, then data bits 0 to 7, then a 1 stop bit, and each bit lasts 16 ticks of os_tick.
- R4: The transmit-ready override is bit 7 of the control register (offset 0x4). While it is 0, no frame starts while cts_n is high, and the held byte stays held. While it is 1, cts_n has no effect.
- R5: A well-formed frame on rxd sets bit 8 of the data register and shows the byte in bits 7:0. Each bit is sampled at its midpoint, which is 8 ticks after the start edge and then every 16 ticks, so bit periods a few percent off nominal are still received.
- R6: Writing the data register with bit 8 set clears bit 8. With bit 8 clear, the waiting byte and its flag are kept.
- R7: A frame whose stop bit samples low is discarded and does not set bit 8. The receiver then waits for the line to go high before it looks for another start bit.
- R8: If a frame completes while bit 8 is still set, the new byte is dropped, the waiting byte is kept, and the overrun flag (control bit 12) is set. Writing 1 to control bit 12 clears it.
- R9: Control bits 3:2 (interface mode: 1 means DTE, 2 means DCE), 7 and 8 (receive-ready override) are stored and read back. All other control bits except 12 read 0.
- R10: The clock register (offset 0x8) stores a scale in bits 27:16 and a step in bits 15:0. Bits 31:28 read 0, and the same 32-bit value drives brg_cfg.
- R11: A write with bit 9 set while the transmit holding stage is full is ignored. The byte already held is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cts_n | input | 1 | Clear-to-send, active low |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| brg_cfg | output | 32 | Scale and step for the external bit-rate generator |

## Verification
Two situations are hardest to reach from the ports. The first is a launch write that arrives while the holding stage is already full. The bench reaches it by leaving the override clear and cts_n high, so the first byte is pinned in the holding stage while a second launch write is issued. It then releases cts_n and decodes which byte appears on txd. The second is an overrun, which needs two complete frames with no acknowledge between them. The bench drives rxd itself to deliver these. Finally, a loopback of txd into rxd sweeps all 256 byte values through both serializers, and the bench decodes every frame independently at the bit midpoints.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;

   localparam int BYTE_W        = 8;
   localparam int BUS_W         = 32;

   // word indexes of the three registers
   localparam int REG_DATA      = 0;
   localparam int REG_CTRL      = 1;
   localparam int REG_CLK       = 2;

   // data word fields
   localparam int DAT_RXV_BIT   = 8;
   localparam int DAT_TXR_BIT   = 9;

   // control word fields
   localparam int CTL_MODE_LSB  = 2;
   localparam int CTL_TXOVR_BIT = 7;
   localparam int CTL_RXOVR_BIT = 8;
   localparam int CTL_OVRN_BIT  = 12;

   // clock word fields
   localparam int CLK_STEP_W    = 16;
   localparam int CLK_SCALE_W   = 12;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_WAIT_HI
   } rx_state_t;

endpackage

// File: rtl/uart_mmio_sync.sv
module uart_mmio_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= {STAGES{RST_VAL}};
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_mmio_tx.sv
module uart_mmio_tx #(
   parameter int OVERSAMPLE = 16,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              load_req,
   input  logic [DATA_W-1:0] load_data,
   output logic              accept,
   output logic              txd
);

   localparam int FRAME_BITS = DATA_W + 2;
   localparam int CNT_W      = $clog2(OVERSAMPLE);
   localparam int BIT_W      = $clog2(FRAME_BITS);

   logic                  busy;
   logic [FRAME_BITS-1:0] shreg;
   logic [CNT_W-1:0]      tick_cnt;
   logic [BIT_W-1:0]      bit_cnt;

   assign accept = !busy && load_req;
   assign txd    = shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         shreg    <= '1;
         tick_cnt <= '0;
         bit_cnt  <= '0;
      end else if (!busy) begin
         if (load_req) begin
            busy     <= 1'b1;
            shreg    <= {1'b1, load_data, 1'b0};
            tick_cnt <= '0;
            bit_cnt  <= '0;
         end
      end else if (os_tick) begin
         if (tick_cnt == CNT_W'(OVERSAMPLE - 1)) begin
            tick_cnt <= '0;
            shreg    <= {1'b1, shreg[FRAME_BITS-1:1]};
            if (bit_cnt == BIT_W'(FRAME_BITS - 1)) begin
               busy <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end else begin
            tick_cnt <= tick_cnt + 1'b1;
         end
      end
   end

   // R3
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !txd);

   // R3
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

endmodule

// File: rtl/uart_mmio_rx.sv
module uart_mmio_rx
   import uart_mmio_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rxd_s,
   output logic              frame_done,
   output logic [DATA_W-1:0] frame_data
);

   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int BIT_W = $clog2(DATA_W);
   localparam int HALF  = OVERSAMPLE / 2;

   rx_state_t         state;
   logic [CNT_W-1:0]  tick_cnt;
   logic [BIT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;

   assign frame_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         tick_cnt   <= '0;
         bit_cnt    <= '0;
         shreg      <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (!rxd_s) begin
                  state    <= RX_START;
                  tick_cnt <= '0;
               end
            end
            RX_START: begin
               if (os_tick) begin
                  if (tick_cnt == CNT_W'(HALF - 1)) begin
                     tick_cnt <= '0;
                     bit_cnt  <= '0;
                     state    <= rxd_s ? RX_IDLE : RX_DATA;
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (os_tick) begin
                  if (tick_cnt == CNT_W'(OVERSAMPLE - 1)) begin
                     tick_cnt <= '0;
                     shreg    <= {rxd_s, shreg[DATA_W-1:1]};
                     if (bit_cnt == BIT_W'(DATA_W - 1)) begin
                        state <= RX_STOP;
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (os_tick) begin
                  if (tick_cnt == CNT_W'(OVERSAMPLE - 1)) begin
                     tick_cnt <= '0;
                     if (rxd_s) begin
                        frame_done <= 1'b1;
                        state      <= RX_IDLE;
                     end else begin
                        state <= RX_WAIT_HI;
                     end
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
            end
            RX_WAIT_HI: begin
               if (rxd_s) begin
                  state <= RX_IDLE;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R7
   stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(rxd_s));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

endmodule

// File: rtl/uart_mmio_core.sv
module uart_mmio_core
   import uart_mmio_pkg::*;
#(
   parameter int          ADDR_W      = 4,
   parameter int          OVERSAMPLE  = 16,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] CLK_RST     = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              os_tick,
   input  logic              cts_n,
   input  logic              rxd,
   output logic              txd,
   output logic [BUS_W-1:0]  brg_cfg
);

   localparam int IDX_W   = ADDR_W - 2;
   localparam int CLK_USE = CLK_STEP_W + CLK_SCALE_W;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must cover three word registers");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   // ---------------- register decode
   logic [IDX_W-1:0] widx;
   logic             wr_data, wr_ctrl, wr_clk;

   assign widx    = bus_addr[ADDR_W-1:2];
   assign wr_data = bus_wr && (widx == IDX_W'(REG_DATA));
   assign wr_ctrl = bus_wr && (widx == IDX_W'(REG_CTRL));
   assign wr_clk  = bus_wr && (widx == IDX_W'(REG_CLK));

   // ---------------- synchronizers
   logic cts_n_s, rxd_s;

   uart_mmio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cts (
      .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_n_s));

   uart_mmio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rxd (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

   // ---------------- control and clock registers
   logic [1:0]             if_mode;
   logic                   tx_ovr, rx_ovr;
   logic [CLK_SCALE_W-1:0] clk_scale;
   logic [CLK_STEP_W-1:0]  clk_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         if_mode   <= '0;
         tx_ovr    <= 1'b0;
         rx_ovr    <= 1'b0;
         clk_scale <= CLK_RST[CLK_USE-1:CLK_STEP_W];
         clk_step  <= CLK_RST[CLK_STEP_W-1:0];
      end else begin
         if (wr_ctrl) begin
            if_mode <= bus_wdata[CTL_MODE_LSB+1:CTL_MODE_LSB];
            tx_ovr  <= bus_wdata[CTL_TXOVR_BIT];
            rx_ovr  <= bus_wdata[CTL_RXOVR_BIT];
         end
         if (wr_clk) begin
            clk_scale <= bus_wdata[CLK_USE-1:CLK_STEP_W];
            clk_step  <= bus_wdata[CLK_STEP_W-1:0];
         end
      end
   end

   assign brg_cfg = {{(BUS_W-CLK_USE){1'b0}}, clk_scale, clk_step};

   // ---------------- transmit holding stage
   logic              hold_full;
   logic [BYTE_W-1:0] hold_byte;
   logic              tx_go, tx_accept;

   assign tx_go = hold_full && (tx_ovr || !cts_n_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_byte <= '0;
      end else if (tx_accept) begin
         hold_full <= 1'b0;
      end else if (wr_data && bus_wdata[DAT_TXR_BIT] && !hold_full) begin
         hold_full <= 1'b1;
         hold_byte <= bus_wdata[BYTE_W-1:0];
      end
   end

   uart_mmio_tx #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(BYTE_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
      .load_req(tx_go), .load_data(hold_byte),
      .accept(tx_accept), .txd(txd));

   // ---------------- receive holding stage
   logic              rx_done;
   logic [BYTE_W-1:0] rx_data;
   logic              rx_full, overrun;
   logic [BYTE_W-1:0] rx_byte;
   logic              rx_ack, ovr_clr;

   assign rx_ack  = wr_data && bus_wdata[DAT_RXV_BIT];
   assign ovr_clr = wr_ctrl && bus_wdata[CTL_OVRN_BIT];

   uart_mmio_rx #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(BYTE_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_s(rxd_s),
      .frame_done(rx_done), .frame_data(rx_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_full <= 1'b0;
         rx_byte <= '0;
         overrun <= 1'b0;
      end else begin
         if (rx_done && rx_full && !rx_ack) begin
            overrun <= 1'b1;
         end else begin
            if (ovr_clr) begin
               overrun <= 1'b0;
            end
            if (rx_done) begin
               rx_full <= 1'b1;
               rx_byte <= rx_data;
            end else if (rx_ack) begin
               rx_full <= 1'b0;
            end
         end
      end
   end

   // ---------------- read mux
   logic unused_bus;
   assign unused_bus = ^{bus_wdata[BUS_W-1:CLK_USE], bus_addr[1:0], if_mode[0]};

   always_comb begin
      bus_rdata = '0;
      case (widx)
         IDX_W'(REG_DATA): begin
            bus_rdata[BYTE_W-1:0]  = rx_byte;
            bus_rdata[DAT_RXV_BIT] = rx_full;
            bus_rdata[DAT_TXR_BIT] = !hold_full;
         end
         IDX_W'(REG_CTRL): begin
            bus_rdata[CTL_MODE_LSB+1:CTL_MODE_LSB] = if_mode;
            bus_rdata[CTL_TXOVR_BIT] = tx_ovr;
            bus_rdata[CTL_RXOVR_BIT] = rx_ovr;
            bus_rdata[CTL_OVRN_BIT]  = overrun;
         end
         IDX_W'(REG_CLK): begin
            bus_rdata = brg_cfg;
         end
         default: bus_rdata = '0;
      endcase
   end

   // R11
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_full && !tx_accept) |=> (hold_full && $stable(hold_byte)));

   // R4
   cts_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_full && !tx_ovr && cts_n_s) |=> hold_full);

   // R6
   rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rx_ack) |=> rx_full);

   // R8
   ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> (rx_full && $stable(rx_byte)));

endmodule

// File: tb/tb_uart_mmio_core.sv
module tb_uart_mmio_core;

   localparam int BITC = 32;   // clocks per bit: 16 ticks, one tick every 2 clocks

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        os_tick = 1'b0;
   logic        cts_n = 1'b1;
   logic        bench_rxd = 1'b1;
   logic        loop_en = 1'b0;
   logic        rxd;
   logic        txd;
   logic [31:0] brg_cfg;

   int n_chk = 0;
   int n_pass = 0;

   assign rxd = loop_en ? txd : bench_rxd;

   always #5 clk = ~clk;

   always @(negedge clk) os_tick <= ~os_tick;

   uart_mmio_core dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .os_tick(os_tick),
      .cts_n(cts_n), .rxd(rxd), .txd(txd), .brg_cfg(brg_cfg));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (ok) n_pass++;
      else $display("FAIL %s actual=%h expected=%h", req, act, exp);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop, input int per);
      @(negedge clk);
      bench_rxd = 1'b0;
      repeat (per) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         bench_rxd = b[i];
         repeat (per) @(negedge clk);
      end
      bench_rxd = stop;
      repeat (per) @(negedge clk);
      bench_rxd = 1'b1;
      repeat (2 * per) @(negedge clk);
   endtask

   task automatic tx_decode(output logic [7:0] b, output logic stop, output bit found);
      found = 1'b0;
      b = 8'h0;
      stop = 1'b0;
      for (int i = 0; i < 3000 && !found; i++) begin
         @(negedge clk);
         if (!txd) found = 1'b1;
      end
      if (found) begin
         repeat (BITC / 2) @(negedge clk);
         for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            b[i] = txd;
         end
         repeat (BITC) @(negedge clk);
         stop = txd;
      end
   endtask

   task automatic line_quiet(input int n, output bit quiet);
      quiet = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!txd) quiet = 1'b0;
      end
   endtask

   task automatic wait_rx(output logic [31:0] d);
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         rd(4'h0, d);
         if (d[8]) break;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 190000, 0);
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  b;
      logic        stp;
      bit          fnd, q;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'h0, d); chk(d == 32'h200, "R1 data reset", d, 32'h200);
      rd(4'h4, d); chk(d == 32'h0,   "R1 ctrl reset", d, 32'h0);
      rd(4'h8, d); chk(d == 32'h0,   "R1 clk reset",  d, 32'h0);
      rd(4'hC, d); chk(d == 32'h0,   "R1 unmapped",   d, 32'h0);
      chk(txd == 1'b1, "R3 idle line", {31'h0, txd}, 32'h1);

      // R4 cts blocks with override clear; R2 bit 9 low while held
      wr(4'h0, 32'h200 | 32'hA5);
      rd(4'h0, d); chk(d[9] == 1'b0, "R2 ready low after load", d, 32'h0);
      line_quiet(300, q);
      chk(q, "R4 no frame while cts_n high", {31'h0, q}, 32'h1);
      rd(4'h0, d); chk(d[9] == 1'b0, "R4 byte still held", d, 32'h0);

      // R11 second launch while full is ignored
      wr(4'h0, 32'h200 | 32'h3C);
      cts_n = 1'b0;
      tx_decode(b, stp, fnd);
      chk(fnd && b == 8'hA5 && stp, "R11 held byte sent", {23'h0, stp, b}, 32'h1A5);
      line_quiet(400, q);
      chk(q, "R11 ignored byte not sent", {31'h0, q}, 32'h1);
      rd(4'h0, d); chk(d[9] == 1'b1, "R2 ready after accept", d, 32'h200);

      // R2 write without bit 9 sends nothing
      wr(4'h0, 32'h0000_0077);
      line_quiet(300, q);
      chk(q, "R2 no launch without bit 9", {31'h0, q}, 32'h1);

      // R9 control fields
      wr(4'h4, 32'hFFFF_FFFF);
      rd(4'h4, d); chk(d == 32'h18C, "R9 ctrl all ones", d, 32'h18C);
      wr(4'h4, 32'h0000_0188);
      rd(4'h4, d); chk(d == 32'h188, "R9 ctrl DCE+overrides", d, 32'h188);

      // R4 override set: cts_n ignored
      cts_n = 1'b1;
      wr(4'h0, 32'h200 | 32'h66);
      tx_decode(b, stp, fnd);
      chk(fnd && b == 8'h66 && stp, "R4 override sends", {23'h0, stp, b}, 32'h166);

      // R10 clock register
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, d); chk(d == 32'h0FFF_FFFF, "R10 clk mask", d, 32'h0FFF_FFFF);
      wr(4'h8, 32'h0123_4567);
      rd(4'h8, d); chk(d == 32'h0123_4567, "R10 clk readback", d, 32'h0123_4567);
      chk(brg_cfg == 32'h0123_4567, "R10 brg_cfg", brg_cfg, 32'h0123_4567);

      // R5 receive, nominal and off-nominal bit periods
      send_frame(8'h5A, 1'b1, BITC);
      rd(4'h0, d); chk(d[8:0] == 9'h15A, "R5 rx nominal", d, 32'h35A);
      wr(4'h0, 32'h0);
      rd(4'h0, d); chk(d[8:0] == 9'h15A, "R6 zero bit 8 keeps byte", d, 32'h35A);
      wr(4'h0, 32'h100);
      rd(4'h0, d); chk(d[8] == 1'b0, "R6 ack clears", d, 32'h25A);
      send_frame(8'hC9, 1'b1, BITC - 1);
      rd(4'h0, d); chk(d[8:0] == 9'h1C9, "R5 rx short bits", d, 32'h3C9);
      wr(4'h0, 32'h100);
      send_frame(8'h2E, 1'b1, BITC + 1);
      rd(4'h0, d); chk(d[8:0] == 9'h12E, "R5 rx long bits", d, 32'h32E);
      wr(4'h0, 32'h100);

      // R7 bad stop bit
      send_frame(8'h33, 1'b0, BITC);
      rd(4'h0, d); chk(d[8] == 1'b0, "R7 bad stop discarded", d, 32'h200);
      send_frame(8'h81, 1'b1, BITC);
      rd(4'h0, d); chk(d[8:0] == 9'h181, "R7 recovers", d, 32'h381);

      // R8 overrun
      send_frame(8'hC3, 1'b1, BITC);
      rd(4'h0, d); chk(d[8:0] == 9'h181, "R8 old byte kept", d, 32'h381);
      rd(4'h4, d); chk(d[12] == 1'b1, "R8 overrun set", d, 32'h1188);
      wr(4'h4, 32'h0000_1188);
      rd(4'h4, d); chk(d == 32'h188, "R8 overrun cleared", d, 32'h188);
      wr(4'h0, 32'h100);
      send_frame(8'h4D, 1'b1, BITC);
      rd(4'h0, d); chk(d[8:0] == 9'h14D, "R8 next byte taken", d, 32'h34D);
      wr(4'h0, 32'h100);

      // R3/R5 loopback sweep over every byte value
      loop_en = 1'b1;
      repeat (40) @(negedge clk);
      for (int v = 0; v < 256; v++) begin
         wr(4'h0, 32'h200 | 32'(v));
         tx_decode(b, stp, fnd);
         chk(fnd && b == 8'(v) && stp, "R3 tx frame", {23'h0, stp, b}, 32'h100 | 32'(v));
         wait_rx(d);
         chk(d[8:0] == (9'h100 | 9'(v)), "R5 loopback rx", d, 32'h100 | 32'(v));
         wr(4'h0, 32'h100);
         rd(4'h0, d);
         chk(d[8] == 1'b0, "R6 loopback ack", d, 32'(v));
      end

      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
   end

endmodule